// File: doc/BRIEF.md
# 64-bit Compare Timer

A single-hart timer peripheral behind a simple 32-bit register port. A 64-bit tick count advances while software has the timer switched on. A prescaler divides the clock, and each prescaler wrap adds a configurable step to the count. A 64-bit compare value, written as two 32-bit halves, is checked against the count on every cycle.

The block has two interrupt outputs. The raw timer line is high for as long as the running count has reached the compare value. It suits a core's machine-timer input, and software silences it by moving the compare value. A second, maskable line follows a sticky status bit. The status bit is set by a compare match or by a software test write while the interrupt is enabled, and software clears it by writing 1.

Software reaches the registers through a byte address, a write strobe and a read strobe. Read data arrives one cycle after the read strobe. Every access is a full 32-bit word.

Top module: `cmp_timer64`

## Requirements
- R1: Control register at offset 0x000, bit 0 = run. Only bit 0 is stored and read back. While run is 0: the count holds, the raw line is low and the prescale phase is held at zero.
- R2: Config register at offset 0x100 holds the prescale value in bits 11:0 and the step in bits 23:16. It resets to 0x00010000 (prescale 0, step 1) and reads back only those fields.
- R3: While running, the count increases by step once every prescale+1 clocks. The first increment comes prescale+1 clock edges after the edge that set run.
- R4: The count's low word is at 0x104 and its high word at 0x108. Both read back and are writable, and a write replaces that word at the next edge. The count carries from the low word into the high word.
- R5: The compare low word is at 0x10C and the high word at 0x110, both resetting to 0xFFFFFFFF. The raw line is high exactly when run is 1 and the 64-bit compare value is less than or equal to the 64-bit count.
- R6: When run is 1, the compare condition holds and enable bit 0 is set, status bit 0 is set at the next edge. It then stays set until cleared, and the maskable output equals status bit 0.
- R7: A write to status (0x118) with bit 0 = 1 clears the bit at that edge, and writing bit 0 = 0 leaves it unchanged. The clear takes priority. If the set condition still holds, the bit is set again one edge later.
- R8: The test register at 0x11C stores bit 0 and reads it back. Writing bit 0 = 1 while enable bit 0 is set sets status bit 0 at that edge. With enable clear, the write leaves status unchanged.
- R9: The enable register at 0x114 stores bit 0 only. Enable, status and test all reset to 0, and with enable clear a compare match does not set status.
- R10: The read data register loads at the edge where the read strobe is high. A read of an unmapped word returns 0, and a write to an unmapped word changes no register. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 10 | Byte offset within the 0x400 window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after re_i |
| tick_irq_o | output | 1 | Raw compare interrupt |
| intr_o | output | 1 | Maskable sticky interrupt |

## Verification
The bench uses the default parameters: a 12-bit prescale field, an 8-bit step and a 10-bit address. It runs the prescaler at 0 and at 3 with steps of 1 and 5 to pin down the exact tick spacing. Loading the maximum prescale, 0xFFF, freezes the count for thousands of cycles, so compare equality, the high compare word and the interrupt clear-and-reassert cycle can be checked against a fixed count.

// File: rtl/cmp_timer64.sv
module cmp_timer64 #(
  parameter int ADDR_W     = 10,
  parameter int PRESCALE_W = 12,
  parameter int STEP_W     = 8,
  parameter int STEP_LSB   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              tick_irq_o,
  output logic              intr_o
);
  localparam int WW = ADDR_W - 2;
  localparam logic [WW-1:0] W_CTRL  = WW'(12'h000 >> 2);
  localparam logic [WW-1:0] W_CFG   = WW'(12'h100 >> 2);
  localparam logic [WW-1:0] W_CLO   = WW'(12'h104 >> 2);
  localparam logic [WW-1:0] W_CHI   = WW'(12'h108 >> 2);
  localparam logic [WW-1:0] W_MLO   = WW'(12'h10C >> 2);
  localparam logic [WW-1:0] W_MHI   = WW'(12'h110 >> 2);
  localparam logic [WW-1:0] W_IE    = WW'(12'h114 >> 2);
  localparam logic [WW-1:0] W_IS    = WW'(12'h118 >> 2);
  localparam logic [WW-1:0] W_IT    = WW'(12'h11C >> 2);

  logic [WW-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  logic                  active_q, ie_q, st_q, it_q;
  logic [PRESCALE_W-1:0] presc_q, pscnt_q;
  logic [STEP_W-1:0]     step_q;
  logic [63:0]           cnt_q, cmp_q;

  wire wr_ctrl = we_i && word == W_CTRL;
  wire wr_cfg  = we_i && word == W_CFG;
  wire wr_clo  = we_i && word == W_CLO;
  wire wr_chi  = we_i && word == W_CHI;
  wire wr_mlo  = we_i && word == W_MLO;
  wire wr_mhi  = we_i && word == W_MHI;
  wire wr_ie   = we_i && word == W_IE;
  wire wr_is   = we_i && word == W_IS;
  wire wr_it   = we_i && word == W_IT;

  wire wrap = active_q && (pscnt_q == presc_q);

  assign tick_irq_o = active_q && (cmp_q <= cnt_q);
  assign intr_o     = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      presc_q  <= '0;
      step_q   <= STEP_W'(1);
      cmp_q    <= '1;
      ie_q     <= 1'b0;
      it_q     <= 1'b0;
    end else begin
      if (wr_ctrl) active_q <= wdata_i[0];
      if (wr_cfg) begin
        presc_q <= wdata_i[PRESCALE_W-1:0];
        step_q  <= wdata_i[STEP_LSB +: STEP_W];
      end
      if (wr_mlo) cmp_q[31:0]  <= wdata_i;
      if (wr_mhi) cmp_q[63:32] <= wdata_i;
      if (wr_ie)  ie_q <= wdata_i[0];
      if (wr_it)  it_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pscnt_q <= '0;
    else if (!active_q || wrap)  pscnt_q <= '0;
    else                         pscnt_q <= pscnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_clo || wr_chi) begin
      if (wr_clo) cnt_q[31:0]  <= wdata_i;
      if (wr_chi) cnt_q[63:32] <= wdata_i;
    end else if (wrap) cnt_q <= cnt_q + 64'(step_q);
  end

  wire st_set = ie_q && (tick_irq_o || (wr_it && wdata_i[0]));
  wire st_clr = wr_is && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= 1'b0;
    else if (st_clr) st_q <= 1'b0;
    else if (st_set) st_q <= 1'b1;
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (word)
      W_CTRL:  rd_mux = {31'd0, active_q};
      W_CFG:   rd_mux = 32'(presc_q) | (32'(step_q) << STEP_LSB);
      W_CLO:   rd_mux = cnt_q[31:0];
      W_CHI:   rd_mux = cnt_q[63:32];
      W_MLO:   rd_mux = cmp_q[31:0];
      W_MHI:   rd_mux = cmp_q[63:32];
      W_IE:    rd_mux = {31'd0, ie_q};
      W_IS:    rd_mux = {31'd0, st_q};
      W_IT:    rd_mux = {31'd0, it_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/cmp_timer64_chk.sv
module cmp_timer64_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              tick_irq_o,
  input logic              intr_o,
  input logic              active_q,
  input logic              ie_q,
  input logic [63:0]       cnt_q
);
  logic [ADDR_W-3:0] w;
  assign w = addr_i[ADDR_W-1:2];
  wire mapped  = (w == '0) || (w >= (ADDR_W-2)'(8'h40) && w <= (ADDR_W-2)'(8'h47));
  wire cnt_wr  = we_i && (w == (ADDR_W-2)'(8'h41) || w == (ADDR_W-2)'(8'h42));
  wire clr_wr  = we_i && w == (ADDR_W-2)'(8'h46) && wdata_i[0];
  wire test_wr = we_i && w == (ADDR_W-2)'(8'h47) && wdata_i[0];

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !tick_irq_o);

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !cnt_wr) |=> $stable(cnt_q));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_o && !clr_wr) |=> intr_o);

  p_clear_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> !intr_o);

  p_test_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_wr && ie_q && !clr_wr) |=> intr_o);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> rdata_o == 32'd0);
endmodule

bind cmp_timer64 cmp_timer64_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_irq_o(tick_irq_o), .intr_o(intr_o),
  .active_q(active_q), .ie_q(ie_q), .cnt_q(cnt_q)
);

// File: tb/test_cmp_timer64.sv
`timescale 1ns/1ps
module test_cmp_timer64;
  localparam logic [9:0] A_CTRL = 10'h000, A_CFG = 10'h100, A_CLO = 10'h104,
    A_CHI = 10'h108, A_MLO = 10'h10C, A_MHI = 10'h110, A_IE = 10'h114,
    A_IS = 10'h118, A_IT = 10'h11C;

  logic clk = 0, rst_n = 0, we = 0, re = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tick, intr;
  int checks = 0, errors = 0;
  logic done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cmp_timer64 i_cmp_timer64 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_irq_o(tick), .intr_o(intr));

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    re = 1; addr = a;
    @(negedge clk);
    re = 0;
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: pin got %b expected %b", tag, act, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (re) begin
        @(negedge clk);
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: unexpected read got %h expected none", rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (rdata !== e) begin
            errors++;
            $display("FAIL %s: read got %h expected %h", t, rdata, e);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tick, 0, "R5"); chk(intr, 0, "R6");
    rd(A_CTRL, 0, "R1");
    rd(A_CFG, 32'h0001_0000, "R2");
    rd(A_CLO, 0, "R4"); rd(A_CHI, 0, "R4");
    rd(A_MLO, 32'hFFFF_FFFF, "R5"); rd(A_MHI, 32'hFFFF_FFFF, "R5");
    rd(A_IE, 0, "R9"); rd(A_IS, 0, "R9"); rd(A_IT, 0, "R9");

    // R3: prescale 0, step 1, active over 10 edges
    wr(A_CTRL, 1); repeat (9) @(negedge clk); wr(A_CTRL, 0);
    rd(A_CLO, 10, "R3");
    repeat (5) @(negedge clk);
    rd(A_CLO, 10, "R1");

    // R3: prescale 3, step 5, active over 12 edges -> 3 wraps
    wr(A_CFG, 32'h0005_0003); wr(A_CLO, 0);
    rd(A_CFG, 32'h0005_0003, "R2");
    wr(A_CTRL, 1); repeat (11) @(negedge clk); wr(A_CTRL, 0);
    rd(A_CLO, 15, "R3");

    // R4: carry across halves
    wr(A_CFG, 32'h0001_0000); wr(A_CHI, 1); wr(A_CLO, 32'hFFFF_FFFE);
    wr(A_CTRL, 1); @(negedge clk); wr(A_CTRL, 0);
    rd(A_CLO, 0, "R4"); rd(A_CHI, 2, "R4");

    // R5: compare with frozen count 0x20
    wr(A_CFG, 32'h0001_0FFF); rd(A_CFG, 32'h0001_0FFF, "R2");
    wr(A_CHI, 0); wr(A_CLO, 32'h20);
    wr(A_MHI, 0); wr(A_MLO, 32'h21);
    wr(A_CTRL, 1); chk(tick, 0, "R5");
    wr(A_MLO, 32'h20); chk(tick, 1, "R5");
    wr(A_MLO, 32'h1F); chk(tick, 1, "R5");
    wr(A_MHI, 1);      chk(tick, 0, "R5");
    wr(A_MHI, 0);      chk(tick, 1, "R5");
    chk(intr, 0, "R9");
    wr(A_CTRL, 0);     chk(tick, 0, "R1");

    // R6: sticky status
    wr(A_IE, 1); @(negedge clk); chk(intr, 0, "R6");
    wr(A_CTRL, 1); chk(intr, 0, "R6");
    @(negedge clk); chk(intr, 1, "R6");
    wr(A_MLO, 32'h40); @(negedge clk); chk(intr, 1, "R6");
    rd(A_IS, 1, "R6");

    // R7: write-1-to-clear
    wr(A_IS, 0); chk(intr, 1, "R7");
    wr(A_IS, 1); chk(intr, 0, "R7");
    @(negedge clk); chk(intr, 0, "R7");
    wr(A_MLO, 32'h10); @(negedge clk); chk(intr, 1, "R7");
    wr(A_IS, 1); chk(intr, 0, "R7");
    @(negedge clk); chk(intr, 1, "R7");

    // R9: enable cleared blocks the set
    wr(A_IE, 0); wr(A_IS, 1); @(negedge clk); chk(intr, 0, "R9");
    rd(A_IE, 0, "R9");

    // R8: test injection
    wr(A_IT, 1); @(negedge clk); chk(intr, 0, "R8");
    rd(A_IT, 1, "R8");
    wr(A_MLO, 32'h40); wr(A_IE, 1); chk(intr, 0, "R8");
    wr(A_IT, 1); chk(intr, 1, "R8");
    wr(A_IS, 1); chk(intr, 0, "R8");

    // R10: unmapped accesses
    rd(10'h200, 0, "R10"); rd(10'h004, 0, "R10");
    wr(10'h120, 32'hFFFF_FFFF); wr(10'h004, 32'h0); wr(10'h3FC, 32'h0);
    rd(A_CTRL, 1, "R10"); rd(A_IE, 1, "R10"); rd(A_IT, 1, "R10");
    rd(A_MLO, 32'h40, "R10");
    chk(intr, 0, "R10");
    rd(A_CFG + 10'h2, 32'h0001_0FFF, "R10");

    // R1: only bit 0 stored
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, 0, "R1");
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, 1, "R1");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule